// File: doc/BRIEF.md
# Three-Axis Sample FIFO Controller

This block stores three-axis acceleration samples between a sampling front end and a host that reads them over a register bus. Each entry packs three 12-bit axis values. The front end pulses a sample-valid strobe with the three values. The host pulses a read-complete strobe once it has fetched all six data bytes of the head entry, and only that strobe moves the read side.

Software picks the capture policy. Plain mode stores samples until the buffer is full and then drops new ones. Watermark mode stops storing once the occupancy reaches a programmed threshold. Stream mode keeps a moving window by replacing the oldest entry when the buffer is full. A freeze request stops capture when a wake-detect event fires, so the history leading up to that event is kept. Level flags (empty, full, at-threshold) follow the occupancy. Three sticky interrupt flags, each with its own enable and a common clear, report those levels to the host.

Top module: `accel_fifo`

## Requirements
- R1: After reset, and in the cycle after a flush pulse, the occupancy is 0, empty is 1, and the head outputs are all zero. A flush also ends a freeze.
- R2: Accepted samples leave in arrival order. The head outputs show the oldest stored entry, and the occupancy counts stored entries.
- R3: Full is 1 only when all DEPTH (32) entries are used. With stream mode off, a sample arriving while full is not stored and the contents do not change.
- R4: With watermark mode on, a sample arriving while the occupancy is greater than or equal to the threshold is dropped.
- R5: With stream mode on and watermark mode off, a sample arriving while full replaces the oldest entry. The occupancy stays at 32 and the head moves to the next oldest entry.
- R6: While freeze is requested and enable is 1, a wake-detect pulse stops all capture until a flush, or until the freeze request is dropped.
- R7: At-threshold is 1 exactly while the occupancy is greater than or equal to the 5-bit threshold (legal values 1 to 31).
- R8: While enable is 0, samples and read strobes have no effect and no interrupt flag is set.
- R9: A read strobe while the buffer is empty leaves the occupancy at 0. The head outputs keep showing the entry most recently read out.
- R10: When a sample is accepted and a read takes place in the same cycle, the occupancy does not change.
- R11: Interrupt bit 0 (empty) and bit 1 (full) set on the first occurrence of their condition and stay set. After a clear, each sets again only after its condition has gone false and then become true again.
- R12: A flag bit sets only while its enable bit is 1. Bit 2 (at-threshold) sets again after a clear whenever its condition holds. A clear in the same cycle as a set leaves the flags at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Block enable |
| flush | input | 1 | Synchronous buffer reset: clears pointers and contents |
| thresh | input | 5 | Threshold for the at-threshold level and for watermark mode |
| wm_mode | input | 1 | Watermark capture policy |
| stream_mode | input | 1 | Overwrite-oldest capture policy |
| freeze_en | input | 1 | Freeze capture on a wake-detect event |
| wake_evt | input | 1 | Wake-detect event pulse |
| smp_vld | input | 1 | Sample-valid strobe |
| smp_x | input | 12 | X axis sample |
| smp_y | input | 12 | Y axis sample |
| smp_z | input | 12 | Z axis sample |
| rd_done | input | 1 | Host has finished reading the head entry |
| head_x | output | 12 | X value of the head entry |
| head_y | output | 12 | Y value of the head entry |
| head_z | output | 12 | Z value of the head entry |
| level | output | 6 | Number of stored entries |
| empty | output | 1 | Occupancy is zero |
| full | output | 1 | Occupancy equals depth |
| at_thr | output | 1 | Occupancy is at or above the threshold |
| irq_en | input | 3 | Flag enables: bit0 empty, bit1 full, bit2 at-threshold |
| irq_clr | input | 1 | Clear all interrupt flags |
| irq_flags | output | 3 | Sticky flags: bit0 empty, bit1 full, bit2 at-threshold |

## Verification
On every cycle the assertions check that the occupancy never goes past the depth, that a full buffer in plain mode does not drain without a read, that a disabled block holds still, that watermark mode does not grow past the threshold, that simultaneous push and pop keep the level, that an empty read keeps the head, and that a clear always wins. FIFO ordering, the stream-mode moving window, the freeze after a wake event, and the rearm rule of the sticky flags involve sequences over many cycles. Only the bench scenarios can show these, by comparing the outputs against a queue model every cycle through directed corner cases and randomized policy mixes.

// File: rtl/accel_fifo.sv
module accel_fifo #(
  parameter int AXW = 12,
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int EW = 3 * AXW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           flush,
  input  logic [AW-1:0]  thresh,
  input  logic           wm_mode,
  input  logic           stream_mode,
  input  logic           freeze_en,
  input  logic           wake_evt,
  input  logic           smp_vld,
  input  logic [AXW-1:0] smp_x,
  input  logic [AXW-1:0] smp_y,
  input  logic [AXW-1:0] smp_z,
  input  logic           rd_done,
  output logic [AXW-1:0] head_x,
  output logic [AXW-1:0] head_y,
  output logic [AXW-1:0] head_z,
  output logic [AW:0]    level,
  output logic           empty,
  output logic           full,
  output logic           at_thr,
  input  logic [2:0]     irq_en,
  input  logic           irq_clr,
  output logic [2:0]     irq_flags
);

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          frozen;
  logic [EW-1:0] last_q;
  logic [2:0]    armed;
  logic [2:0]    flags_q;

  assign empty  = (cnt == '0);
  assign full   = (cnt == (AW+1)'(DEPTH));
  assign at_thr = (cnt >= {1'b0, thresh});
  assign level  = cnt;

  logic wr, ovw, rd, pop;
  assign wr  = en & smp_vld & ~frozen & (~full | stream_mode) & ~(wm_mode & at_thr);
  assign ovw = wr & full;
  assign rd  = en & rd_done & ~empty;
  assign pop = rd | ovw;

  logic [EW-1:0] head;
  assign head = empty ? last_q : mem[rp];
  assign {head_z, head_y, head_x} = head;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      wp <= '0; rp <= '0; cnt <= '0; frozen <= 1'b0; last_q <= '0;
    end else if (flush) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      wp <= '0; rp <= '0; cnt <= '0; frozen <= 1'b0; last_q <= '0;
    end else begin
      if (wr) begin
        mem[wp] <= {smp_z, smp_y, smp_x};
        wp <= wp + 1'b1;
      end
      if (pop) rp <= rp + 1'b1;
      if (rd) last_q <= mem[rp];
      cnt <= cnt + (AW+1)'(wr) - (AW+1)'(pop);
      if (!freeze_en) frozen <= 1'b0;
      else if (en && wake_evt) frozen <= 1'b1;
    end
  end

  logic [2:0] cond, fire;
  assign cond = {at_thr, full, empty};
  assign fire = {3{en & ~irq_clr}} & irq_en & cond & (armed | 3'b100);
  assign irq_flags = flags_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      armed   <= '1;
    end else begin
      flags_q <= irq_clr ? 3'b000 : (flags_q | fire);
      armed   <= (armed & ~fire) | ~cond;
    end
  end

  AST_LEVEL_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    level <= (AW+1)'(DEPTH)); // R3
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !stream_mode && !rd_done && !flush) |=> full); // R3
  AST_EN_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !flush) |=> $stable(level)); // R8
  AST_WM_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    (en && wm_mode && at_thr && !flush) |=> level <= $past(level)); // R4
  AST_PUSH_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && smp_vld && rd_done && !empty && !full && !frozen && !flush && !(wm_mode && at_thr))
      |=> $stable(level)); // R10
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !smp_vld && !flush) |=> (empty && $stable(head))); // R9
  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr |=> irq_flags == 3'b000); // R12
  AST_EN_GATES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_clr) |=> ((irq_flags & ~$past(irq_flags) & ~$past(irq_en)) == 3'b000)); // R12

endmodule

// File: tb/sim_accel_fifo.sv
module sim_accel_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 32;

  logic clk = 0, rst_n = 0;
  logic en = 0, flush = 0, wm_mode = 0, stream_mode = 0, freeze_en = 0, wake_evt = 0;
  logic smp_vld = 0, rd_done = 0, irq_clr = 0;
  logic [4:0] thresh = 5'd16;
  logic [11:0] smp_x = 0, smp_y = 0, smp_z = 0;
  logic [2:0] irq_en = 0;
  logic [11:0] head_x, head_y, head_z;
  logic [5:0] level;
  logic empty, full, at_thr;
  logic [2:0] irq_flags;

  always #(CLK_PERIOD/2) clk = ~clk;

  accel_fifo u0 (.clk, .rst_n, .en, .flush, .thresh, .wm_mode, .stream_mode,
    .freeze_en, .wake_evt, .smp_vld, .smp_x, .smp_y, .smp_z, .rd_done,
    .head_x, .head_y, .head_z, .level, .empty, .full, .at_thr,
    .irq_en, .irq_clr, .irq_flags);

  int checks = 0, errors = 0;
  logic [35:0] q[$];
  logic [35:0] mlast = 0;
  bit mfrz = 0;
  logic [2:0] mflags = 0, marm = 3'b111;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [35:0] mhead();
    return (q.size() != 0) ? q[0] : mlast;
  endfunction

  task automatic model_next();
    int c = q.size();
    bit e = (c == 0), f = (c == DEPTH), t = (c >= thresh);
    logic [2:0] cond = {t, f, e};
    logic [2:0] fire = {3{en & ~irq_clr}} & irq_en & cond & (marm | 3'b100);
    mflags = irq_clr ? 3'b000 : (mflags | fire);
    marm = (marm & ~fire) | ~cond;
    if (flush) begin
      q.delete(); mlast = 0; mfrz = 0;
    end else begin
      bit wr = en & smp_vld & ~mfrz & (~f | stream_mode) & ~(wm_mode & t);
      bit rd = en & rd_done & ~e;
      if (rd) mlast = q[0];
      if (rd || (wr && f)) void'(q.pop_front());
      if (wr) q.push_back({smp_z, smp_y, smp_x});
      if (!freeze_en) mfrz = 0;
      else if (en && wake_evt) mfrz = 1;
    end
  endtask

  task automatic cyc();
    model_next();
    @(posedge clk);
    @(negedge clk);
    chk(level == 6'(q.size()), "R2 level", level, q.size());
    chk(empty == (q.size() == 0) && full == (q.size() == DEPTH), "R3 empty/full",
        {empty, full}, {q.size() == 0, q.size() == DEPTH});
    chk(at_thr == (q.size() >= thresh), "R7 at_thr", at_thr, q.size() >= thresh);
    chk({head_z, head_y, head_x} == mhead(), "R2 head", {head_z, head_y, head_x}, mhead());
    chk(irq_flags == mflags, "R11 irq_flags", irq_flags, mflags);
  endtask

  task automatic push(input logic [35:0] d);
    {smp_z, smp_y, smp_x} = d; smp_vld = 1; cyc(); smp_vld = 0;
  endtask
  task automatic pop();
    rd_done = 1; cyc(); rd_done = 0;
  endtask
  task automatic do_flush();
    flush = 1; cyc(); flush = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(level == 0 && empty && {head_z, head_y, head_x} == 0, "R1 reset state", level, 0);
    en = 1;
    for (int i = 0; i < DEPTH; i++) push(36'h100 + 36'(i));
    chk(full && level == 6'd32, "R3 full at 32", level, 32);
    push(36'hABC);
    chk(level == 6'd32 && head_x == 12'h100, "R3 drop when full", head_x, 12'h100);
    pop(); pop(); pop();
    chk(head_x == 12'h103 && level == 6'd29, "R2 order", head_x, 12'h103);
    stream_mode = 1;
    for (int i = 0; i < 4; i++) push(36'h200 + 36'(i));
    chk(level == 6'd32 && head_x == 12'h104, "R5 overwrite oldest", head_x, 12'h104);
    stream_mode = 0;
    do_flush();
    chk(level == 0 && empty && {head_z, head_y, head_x} == 0, "R1 flush", level, 0);
    thresh = 5'd4; wm_mode = 1;
    for (int i = 0; i < 10; i++) push(36'h300 + 36'(i));
    chk(level == 6'd4 && at_thr, "R4 watermark drop", level, 4);
    chk(at_thr == 1'b1, "R7 threshold level", at_thr, 1);
    wm_mode = 0; thresh = 5'd16;
    do_flush();
    freeze_en = 1;
    push(36'h1); push(36'h2);
    wake_evt = 1; cyc(); wake_evt = 0;
    push(36'h3); push(36'h4); push(36'h5);
    chk(level == 6'd2, "R6 frozen capture", level, 2);
    freeze_en = 0; cyc();
    push(36'h6);
    chk(level == 6'd3, "R6 freeze released", level, 3);
    irq_en = 3'b111; en = 0;
    push(36'h7); pop(); cyc();
    chk(level == 6'd3 && irq_flags == 0, "R8 disabled", level, 3);
    en = 1; irq_en = 0;
    do_flush();
    push(36'h777);
    pop();
    pop();
    chk(level == 0 && head_x == 12'h777, "R9 empty read", head_x, 12'h777);
    push(36'h11); push(36'h22);
    {smp_z, smp_y, smp_x} = 36'h33; smp_vld = 1; rd_done = 1; cyc(); smp_vld = 0; rd_done = 0;
    chk(level == 6'd2 && head_x == 12'h22, "R10 push and pop", level, 2);
    do_flush();
    irq_en = 3'b001; cyc();
    chk(irq_flags[0] == 1'b1, "R11 empty flag sets", irq_flags, 1);
    irq_clr = 1; cyc(); irq_clr = 0; cyc(); cyc();
    chk(irq_flags[0] == 1'b0, "R11 no rearm while empty", irq_flags, 0);
    push(36'h5); pop(); cyc();
    chk(irq_flags[0] == 1'b1, "R11 rearm after not empty", irq_flags, 1);
    irq_en = 3'b100; thresh = 5'd1; push(36'h9);
    irq_clr = 1; cyc(); cyc();
    chk(irq_flags == 3'b000, "R12 clear wins", irq_flags, 0);
    irq_clr = 0; cyc();
    chk(irq_flags[2] == 1'b1, "R12 threshold resets after clear", irq_flags, 4);
    irq_en = 3'b000; irq_clr = 1; cyc(); irq_clr = 0; cyc();
    chk(irq_flags == 3'b000, "R12 disabled flag stays clear", irq_flags, 0);
    for (int blk = 0; blk < 20; blk++) begin
      thresh = 5'(1 + ($urandom() % 31));
      wm_mode = ($urandom() % 3) == 0;
      stream_mode = ($urandom() % 2) == 0;
      freeze_en = ($urandom() % 5) == 0;
      irq_en = 3'($urandom());
      for (int i = 0; i < 200; i++) begin
        en = ($urandom() % 16) != 0;
        flush = ($urandom() % 150) == 0;
        wake_evt = ($urandom() % 60) == 0;
        smp_vld = ($urandom() % 4) != 0;
        rd_done = ($urandom() % 3) == 0;
        irq_clr = ($urandom() % 20) == 0;
        {smp_z, smp_y, smp_x} = {4'($urandom()), $urandom()};
        cyc();
      end
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule